// File: doc/BRIEF.md
# Serial TDM Audio Frame Receiver

This block sits on the controller side of a codec link that carries time-division multiplexed audio. A free-running bit clock comes from the codec. The block samples the serial input line on that clock and uses the rising edge of the frame-sync line to find the start of each frame. A frame has 256 bits: a 16-bit tag slot comes first, and twelve 20-bit data slots follow it. Each tag bit tells whether the data slot it marks is valid in that same frame.

Five slots are picked out of the stream: the status read-back address, the status read-back data, the left and right record samples, and the GPIO interrupt slot. Each one has its own holding register and a one-cycle valid strobe. A register and its strobe update only when the frame-valid tag bit and the slot's own tag bit are both set. Frame timing is checked against the sync line. A sync edge that arrives at the wrong time, or a sync high phase of the wrong length, sets a sticky error flag, and the receiver aligns again on the next sync edge.

Top module: `tdm_frame_rx`

## Requirements
- R1: `sdata_i` is sampled on the falling edge of `clk_i`. The falling edge that first sees `sync_i` high after it was low is bit 0 of a frame. Bits 0..15 form the tag, MSB first. Data slot k (1..12) then occupies bits 16+20(k-1) .. 16+20k-1, MSB first.
- R2: Slot k is captured only when tag bit 15 (frame valid) and tag bit 15-k are both 1 in the same frame. Otherwise the output keeps its previous value and no strobe is raised.
- R3: `stat_addr_o` takes bits 19..4 of slot 1. `stat_data_o` takes bits 19..4 of slot 2.
- R4: `pcm_left_o` takes all 20 bits of slot 3. `pcm_right_o` takes all 20 bits of slot 4.
- R5: `gpio_irq_o` takes all 20 bits of slot 12.
- R6: A valid strobe goes high on the falling edge that samples the last bit of its slot and stays high for exactly one bit clock. No two strobes are ever high together.
- R7: After reset all outputs and strobes are 0 and `frame_err_o` is 0. Bits received before the first sync rising edge have no effect.
- R8: While aligned, a sync rising edge at any spacing other than 256 bit clocks from the previous frame start sets `frame_err_o`. The receiver restarts the frame at that edge. Slots already completed in the cut-short frame keep their captures.
- R9: If `sync_i` is not high for exactly bits 0..15 of an aligned frame, `frame_err_o` is set and nothing more is captured until the next sync rising edge.
- R10: `frame_err_o` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock; logic acts on its falling edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync |
| sdata_i | input | 1 | Serial data from the codec |
| stat_addr_o | output | 16 | Status read-back address |
| stat_addr_vld_o | output | 1 | Strobe for stat_addr_o |
| stat_data_o | output | 16 | Status read-back data |
| stat_data_vld_o | output | 1 | Strobe for stat_data_o |
| pcm_left_o | output | 20 | Left record sample |
| pcm_left_vld_o | output | 1 | Strobe for pcm_left_o |
| pcm_right_o | output | 20 | Right record sample |
| pcm_right_vld_o | output | 1 | Strobe for pcm_right_o |
| gpio_irq_o | output | 20 | GPIO interrupt slot |
| gpio_irq_vld_o | output | 1 | Strobe for gpio_irq_o |
| frame_err_o | output | 1 | Sticky framing error |

## Verification
Some properties are checked by assertions on every edge. Each strobe lasts a single cycle and no two strobes overlap. An output never changes unless its strobe rises with it, and a strobe needs an accepting tag. The error flag is sticky, and a badly timed sync edge both restarts the counter and sets the error. Other behaviour can only be shown by the bench scenarios. These cover bit order and slot placement, the 16-of-20 truncation, the full sweep over the frame-valid bit and the five tag bits, the slots kept from a cut-short frame, and the short-sync, long-sync, early-edge and late-edge cases followed by realignment.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
package tdm_rx_pkg;
  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_SLOTS = 12;
  localparam int STAT_W    = 16;
  localparam int NUM_CAP   = 5;

  // capture index -> slot number: addr, data, left, right, gpio
  function automatic int cap_slot(int idx, int nslots);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 3;
      3:       return 4;
      default: return nslots;
    endcase
  endfunction
endpackage

// File: rtl/tdm_rx_align.sv
`timescale 1ns/1ps
module tdm_rx_align #(
  parameter int TAG_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  localparam int FRAME_LEN = TAG_W + NUM_SLOTS * SLOT_W,
  localparam int CNT_W     = $clog2(FRAME_LEN) + 1,
  localparam int SLOT_IW   = $clog2(NUM_SLOTS + 2),
  localparam int POS_W     = $clog2((SLOT_W > TAG_W) ? SLOT_W : TAG_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sync_i,
  output logic [SLOT_IW-1:0] slot_o,
  output logic               slot_last_o,
  output logic               frame_err_o
);
  localparam logic [SLOT_IW-1:0] IDLE_SLOT = SLOT_IW'(NUM_SLOTS + 1);
  localparam logic [SLOT_IW-1:0] LAST_SLOT = SLOT_IW'(NUM_SLOTS);
  localparam logic [POS_W-1:0]   TAG_END   = POS_W'(TAG_W - 1);
  localparam logic [POS_W-1:0]   SLOT_END  = POS_W'(SLOT_W - 1);
  localparam logic [CNT_W-1:0]   CNT_END   = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0]   CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0]   CNT_TAG   = CNT_W'(TAG_W);

  logic               sync_q, locked_q, locked_d, err_q, err_d;
  logic               rise, early, sync_bad, active;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [SLOT_IW-1:0] slot_q, slot_d;
  logic [POS_W-1:0]   pos_q, pos_d;

  always_comb begin
    rise     = sync_i & ~sync_q;
    cnt_d    = cnt_q;
    slot_d   = slot_q;
    pos_d    = pos_q;
    locked_d = locked_q;
    if (rise) begin
      cnt_d    = '0;
      slot_d   = '0;
      pos_d    = '0;
      locked_d = 1'b1;
    end else if (locked_q) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      if (slot_q == '0) begin
        if (pos_q == TAG_END) begin
          slot_d = SLOT_IW'(1);
          pos_d  = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end else if (slot_q <= LAST_SLOT) begin
        if (pos_q == SLOT_END) begin
          slot_d = slot_q + 1'b1;
          pos_d  = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
    early    = rise & locked_q & (cnt_q != CNT_END);
    // sync must be high for tag bits 1..15 and low on the first data bit
    sync_bad = ~rise & locked_q &
               (((cnt_d != '0) & (cnt_d < CNT_TAG) & ~sync_i) |
                ((cnt_d == CNT_TAG) & sync_i));
    if (sync_bad) locked_d = 1'b0;
    err_d  = err_q | early | sync_bad;
    active = locked_d & (slot_d <= LAST_SLOT);
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
      cnt_q    <= '0;
      slot_q   <= IDLE_SLOT;
      pos_q    <= '0;
    end else begin
      sync_q   <= sync_i;
      locked_q <= locked_d;
      err_q    <= err_d;
      cnt_q    <= cnt_d;
      slot_q   <= slot_d;
      pos_q    <= pos_d;
    end
  end

  assign slot_o      = slot_d;
  assign slot_last_o = active & ((slot_d == '0) ? (pos_d == TAG_END) : (pos_d == SLOT_END));
  assign frame_err_o = err_q;

  AST_ERR_STICKY: assert property (@(negedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q); // R10
  AST_SYNC_RESTART: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(sync_i) |=> (cnt_q == '0) && (slot_q == '0)); // R1
  AST_EARLY_EDGE_ERR: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ($rose(sync_i) && locked_q && (cnt_q != CNT_END)) |=> err_q); // R8
  AST_SLOT_RANGE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    slot_q <= IDLE_SLOT); // R1
endmodule

// File: rtl/tdm_rx_shift.sv
`timescale 1ns/1ps
module tdm_rx_shift #(
  parameter int TAG_W  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              tag_end_i,
  output logic [SLOT_W-1:0] word_o,
  output logic [TAG_W-1:0]  tag_o
);
  logic [SLOT_W-2:0] sh_q;
  logic [TAG_W-1:0]  tag_q;

  // word includes the bit sampled on this edge
  assign word_o = {sh_q, sdata_i};
  assign tag_o  = tag_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      tag_q <= '0;
    end else begin
      sh_q <= word_o[SLOT_W-2:0];
      if (tag_end_i) tag_q <= word_o[TAG_W-1:0];
    end
  end
endmodule

// File: rtl/tdm_rx_slot_cap.sv
`timescale 1ns/1ps
module tdm_rx_slot_cap #(
  parameter int KEEP_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic              tag_ok_i,
  input  logic [KEEP_W-1:0] word_i,
  output logic [KEEP_W-1:0] data_o,
  output logic              vld_o
);
  logic [KEEP_W-1:0] data_q;
  logic              vld_q;
  logic              take;

  assign take = slot_end_i & tag_ok_i;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) data_q <= word_i;
    end
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;

  AST_STROBE_PULSE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    vld_q |=> !vld_q); // R6
  AST_HOLD_WITHOUT_STROBE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !vld_q |-> $stable(data_q)); // R2
  AST_STROBE_NEEDS_TAG: assert property (@(negedge clk_i) disable iff (!rst_ni)
    vld_q |-> $past(tag_ok_i)); // R2
endmodule

// File: rtl/tdm_frame_rx.sv
`timescale 1ns/1ps
module tdm_frame_rx
  import tdm_rx_pkg::*;
#(
  parameter int TAG_W     = tdm_rx_pkg::TAG_W,
  parameter int SLOT_W    = tdm_rx_pkg::SLOT_W,
  parameter int NUM_SLOTS = tdm_rx_pkg::NUM_SLOTS,
  parameter int STAT_W    = tdm_rx_pkg::STAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sdata_i,
  output logic [STAT_W-1:0] stat_addr_o,
  output logic              stat_addr_vld_o,
  output logic [STAT_W-1:0] stat_data_o,
  output logic              stat_data_vld_o,
  output logic [SLOT_W-1:0] pcm_left_o,
  output logic              pcm_left_vld_o,
  output logic [SLOT_W-1:0] pcm_right_o,
  output logic              pcm_right_vld_o,
  output logic [SLOT_W-1:0] gpio_irq_o,
  output logic              gpio_irq_vld_o,
  output logic              frame_err_o
);
  localparam int SLOT_IW = $clog2(NUM_SLOTS + 2);

  logic [SLOT_IW-1:0] slot_idx;
  logic               slot_last, tag_end;
  logic [SLOT_W-1:0]  word;
  logic [TAG_W-1:0]   tag;
  logic [NUM_CAP-1:0] vld_all;
  logic               unused_tag;

  tdm_rx_align #(
    .TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)
  ) u_align (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .slot_o     (slot_idx),
    .slot_last_o(slot_last),
    .frame_err_o(frame_err_o)
  );

  assign tag_end = slot_last & (slot_idx == '0);

  tdm_rx_shift #(.TAG_W(TAG_W), .SLOT_W(SLOT_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sdata_i  (sdata_i),
    .tag_end_i(tag_end),
    .word_o   (word),
    .tag_o    (tag)
  );

  assign unused_tag = ^tag;

  for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
    localparam int SID = cap_slot(g, NUM_SLOTS);
    localparam int KW  = (g < 2) ? STAT_W : SLOT_W;
    logic [KW-1:0] d;
    logic          v, slot_end, tag_ok;

    assign slot_end = slot_last & (slot_idx == SLOT_IW'(SID));
    assign tag_ok   = tag[TAG_W-1] & tag[TAG_W-1-SID];

    tdm_rx_slot_cap #(.KEEP_W(KW)) u_cap (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .slot_end_i(slot_end),
      .tag_ok_i  (tag_ok),
      .word_i    (word[SLOT_W-1 -: KW]),
      .data_o    (d),
      .vld_o     (v)
    );
    assign vld_all[g] = v;

    if (g == 0) begin : g_addr
      assign stat_addr_o = d;  assign stat_addr_vld_o = v;
    end else if (g == 1) begin : g_data
      assign stat_data_o = d;  assign stat_data_vld_o = v;
    end else if (g == 2) begin : g_left
      assign pcm_left_o = d;   assign pcm_left_vld_o = v;
    end else if (g == 3) begin : g_right
      assign pcm_right_o = d;  assign pcm_right_vld_o = v;
    end else begin : g_gpio
      assign gpio_irq_o = d;   assign gpio_irq_vld_o = v;
    end
  end

  AST_STROBE_EXCLUSIVE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $onehot0(vld_all)); // R6
endmodule

// File: tb/tdm_frame_rx_tb_top.sv
`timescale 1ns/1ps
module tdm_frame_rx_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sd = 1'b0;
  logic [15:0] stat_addr, stat_data;
  logic [19:0] pcm_l, pcm_r, gpio;
  logic        sa_v, sd_v, pl_v, pr_v, gp_v, err;

  tdm_frame_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .sdata_i(sd),
    .stat_addr_o(stat_addr), .stat_addr_vld_o(sa_v),
    .stat_data_o(stat_data), .stat_data_vld_o(sd_v),
    .pcm_left_o(pcm_l), .pcm_left_vld_o(pl_v),
    .pcm_right_o(pcm_r), .pcm_right_vld_o(pr_v),
    .gpio_irq_o(gpio), .gpio_irq_vld_o(gp_v),
    .frame_err_o(err)
  );

  always #4 clk = ~clk;

  int          n_chk = 0, n_fail = 0;
  logic [19:0] exp_val [5];
  logic [19:0] pend_val [5];
  logic [4:0]  pend_vld;
  logic        exp_err, prev_sync, model_locked;
  int          since_rise;
  logic [19:0] cur_slots [12];
  logic [4:0]  act_vld;
  logic [19:0] act_val [5];

  assign act_vld    = {gp_v, pr_v, pl_v, sd_v, sa_v};
  assign act_val[0] = {4'b0, stat_addr};
  assign act_val[1] = {4'b0, stat_data};
  assign act_val[2] = pcm_l;
  assign act_val[3] = pcm_r;
  assign act_val[4] = gpio;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int c);
    if (c < 2) return "R3";
    if (c < 4) return "R4";
    return "R5";
  endfunction

  function automatic int cap_of(input int k);
    case (k)
      1: return 0;
      2: return 1;
      3: return 2;
      4: return 3;
      12: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [19:0] keep(input int c, input logic [19:0] w);
    return (c < 2) ? {4'b0, w[19:4]} : w;
  endfunction

  function automatic logic [19:0] sval(input int f, input int k);
    int v;
    v = (f * 40503 + k * 2654 + 977) ^ (k << 13) ^ (f << 7);
    return 20'(v);
  endfunction

  task automatic fill_slots(input int f);
    for (int k = 0; k < 12; k++) cur_slots[k] = sval(f, k + 1);
  endtask

  // drive one bit at the rising edge; DUT samples on the falling edge
  task automatic drive_bit(input logic s, input logic d);
    @(posedge clk);
    sync = s;
    sd   = d;
    if (s && !prev_sync) begin
      if (model_locked && since_rise != 255) exp_err = 1'b1;
      model_locked = 1'b1;
      since_rise   = 0;
    end else if (since_rise < 100000) begin
      since_rise++;
    end
    prev_sync = s;
    #1;
    chk("R1,R6", "strobes", 32'(act_vld), 32'(pend_vld));
    for (int c = 0; c < 5; c++)
      if (pend_vld[c]) chk(req_of(c), "value", 32'(act_val[c]), 32'(pend_val[c]));
    pend_vld = '0;
  endtask

  task automatic send_frame(input logic [15:0] tag, input int nbits, input int sync_len, input string ereq);
    logic good;
    good = (sync_len == 16);
    for (int i = 0; i < nbits; i++) begin
      logic d;
      int k, b;
      if (i < 16) d = tag[15 - i];
      else if (i < 256) begin
        k = (i - 16) / 20 + 1;
        b = (i - 16) % 20;
        d = cur_slots[k - 1][19 - b];
      end else d = 1'b0;
      drive_bit(i < sync_len, d);
      if (i == 1 && !good) begin
        exp_err      = 1'b1;
        model_locked = 1'b0;
      end
      if (i == 17) begin
        chk(ereq, "frame_err", 32'(err), 32'(exp_err));
        for (int c = 0; c < 5; c++) chk("R2", "hold", 32'(act_val[c]), 32'(exp_val[c]));
      end
      if (good && i >= 16 && i < 256 && ((i - 16) % 20) == 19) begin
        int c;
        k = (i - 16) / 20 + 1;
        c = cap_of(k);
        if (c >= 0 && tag[15] && tag[15 - k]) begin
          pend_vld[c] = 1'b1;
          pend_val[c] = keep(c, cur_slots[k - 1]);
          exp_val[c]  = pend_val[c];
        end
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sync  = 1'b0;
    sd    = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      exp_val[c]  = '0;
      pend_val[c] = '0;
    end
    pend_vld     = '0;
    exp_err      = 1'b0;
    prev_sync    = 1'b0;
    model_locked = 1'b0;
    since_rise   = 0;
    #1;
    chk("R7", "reset strobes", 32'(act_vld), 32'h0);
    chk("R7", "reset err", 32'(err), 32'h0);
    for (int c = 0; c < 5; c++) chk("R7", "reset value", 32'(act_val[c]), 32'h0);
  endtask

  function automatic logic [15:0] sweep_tag(input int c);
    logic [15:0] t;
    t     = {16{~c[1]}};
    t[15] = c[5];
    t[14] = c[0];
    t[13] = c[1];
    t[12] = c[2];
    t[11] = c[3];
    t[3]  = c[4];
    return t;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL R1 watchdog act=hung exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    // R7: garbage before the first sync edge
    for (int i = 0; i < 40; i++) drive_bit(1'b0, 1'(i ^ (i >> 2)));
    for (int c = 0; c < 5; c++) chk("R7", "pre-sync", 32'(act_val[c]), 32'h0);

    // R2: sweep frame-valid bit and the five tag bits
    for (int c = 0; c < 64; c++) begin
      fill_slots(c);
      send_frame(sweep_tag(c), 256, 16, "R8");
    end

    // R8: cut-short frame keeps slots 1..4, next edge flags error and realigns
    fill_slots(100);
    send_frame(16'hFFFF, 150, 16, "R8");
    fill_slots(101);
    send_frame(16'hFFFF, 256, 16, "R8");
    fill_slots(102);
    send_frame(16'hFFFF, 256, 16, "R10");

    // R8: late edge
    do_reset();
    fill_slots(110);
    send_frame(16'hFFFF, 270, 16, "R8");
    fill_slots(111);
    send_frame(16'hFFFF, 256, 16, "R8");

    // R9: short sync high phase
    do_reset();
    fill_slots(120);
    send_frame(16'hFFFF, 256, 16, "R9");
    fill_slots(121);
    send_frame(16'hFFFF, 256, 12, "R9");
    fill_slots(122);
    send_frame(16'hFFFF, 256, 16, "R10");

    // R9: long sync high phase
    do_reset();
    fill_slots(130);
    send_frame(16'hFFFF, 256, 16, "R9");
    fill_slots(131);
    send_frame(16'hFFFF, 256, 20, "R9");
    fill_slots(132);
    send_frame(16'hFFFF, 256, 16, "R10");

    for (int i = 0; i < 3; i++) drive_bit(1'b0, 1'b0);
    chk("R10", "final err", 32'(err), 32'h1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule